// File: doc/BRIEF.md
# Unaligned Word Read Combiner

This block sits between a processor load port and a memory that can only return whole, aligned 32-bit words. The processor may ask for a 32-bit word starting at any byte address. If the address falls on a word boundary, the block issues one memory read and returns that word. If it does not, the block issues two reads on consecutive cycles. The first read is the aligned word that holds the first requested byte. The second read is the aligned word that follows it. The block then merges the two into the requested value and presents it with a one-cycle valid pulse.

Byte order is big-endian throughout. The byte at the lowest address of a word sits in bits [31:24]. Upstream, a request is taken on a valid/ready handshake. Downstream, the memory sees a read enable and a word address, and it returns data exactly one cycle later. Aligned requests finish two cycles after acceptance, and split requests finish three cycles after acceptance. Writes are not handled.

Top module: `ualign_read_combiner`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0. While the block is idle with no request, no memory read is issued.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In that same cycle, `mem_rd_en` is 1 and `mem_addr` equals `req_addr[ADDR_W-1:2]`, which is the byte address rounded down to its word.
- R3: For an aligned request (`req_addr[1:0]` = 0), exactly one read is made. `rsp_valid` is 1 in the second cycle after acceptance, and `rsp_data` is the word that memory returned.
- R4: For an unaligned request, a second read is issued in the cycle after acceptance, at word address `req_addr[ADDR_W-1:2] + 1`.
- R5: An unaligned response appears in the third cycle after acceptance. If memory holds bytes 01..08 at byte addresses 0..7, a request at address 1 returns 0x02030405.
- R6: In general, the result equals (first << 8*off) | (second >> 8*(4-off)), where off = `req_addr[1:0]`. This is checked for off = 2 and off = 3.
- R7: `req_ready` is 0 from the cycle after acceptance until the response cycle. A request held during that time is ignored: it causes no memory read and does not change the response.
- R8: When the rounded-down word is the last word of the address space, the second read wraps to word address 0.
- R9: `rsp_valid` is high for exactly one cycle per accepted request.
- R10: In each memory word, the byte at the lowest address is taken from bits [31:24] and the byte at the highest address from bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the requested word |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the result |
| rsp_data | output | 8*BYTES | Assembled big-endian word |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W-log2(BYTES) | Word address to memory |
| mem_rdata | input | 8*BYTES | Memory data, valid one cycle after the strobe |

## Verification
The bench models memory so that each byte's value is its address plus one. This makes every assembled result unique to its start address and byte order.

Requests are made at all four offsets within a word:
- **Offset 0** confirms the single-read path.
- **Offset 1** confirms the split and the known 0x02030405 result.
- **Offsets 2 and 3** confirm the shift amounts that offset 1 alone cannot tell apart.

The last aligned word and the unaligned address just below the top of memory separate correct wrap-around from an overflowing word address. Requests held during a busy window show whether the handshake is really ignored while `req_ready` is 0.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SECOND = 2'd1,
        ST_LAST   = 2'd2
    } seq_state_e;

    // Bit position (from the MSB end) of a byte lane in a big-endian word.
    function automatic int lane_lsb(input int lane, input int lanes);
        return (lanes - 1 - lane) * BYTE_W;
    endfunction

endpackage

// File: rtl/ualign_addr_split.sv
module ualign_addr_split
    import ualign_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BYTES  = 4,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]  byte_addr,
    output logic [WADDR_W-1:0] word_lo,
    output logic [WADDR_W-1:0] word_hi,
    output logic [OFF_W-1:0]   offset,
    output logic               split
);
    assign word_lo = byte_addr[ADDR_W-1:OFF_W];
    // Natural modulo wrap: the word after the last one is word 0.
    assign word_hi = word_lo + {{(WADDR_W-1){1'b0}}, 1'b1};
    assign offset  = byte_addr[OFF_W-1:0];
    assign split   = |byte_addr[OFF_W-1:0];
endmodule

// File: rtl/ualign_seq.sv
module ualign_seq
    import ualign_pkg::*;
#(
    parameter int WADDR_W = 10,
    parameter int OFF_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [WADDR_W-1:0] word_lo,
    input  logic [WADDR_W-1:0] word_hi,
    input  logic [OFF_W-1:0]   offset,
    input  logic               split,
    output logic               req_ready,
    output logic               mem_rd_en,
    output logic [WADDR_W-1:0] mem_addr,
    output logic               capture_first,
    output logic               finish,
    output logic               split_q,
    output logic [OFF_W-1:0]   offset_q
);
    seq_state_e         state_q, state_d;
    logic [WADDR_W-1:0] word_hi_q;
    logic               accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        mem_rd_en     = 1'b0;
        mem_addr      = word_hi_q;
        capture_first = 1'b0;
        finish        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_addr  = word_lo;
                if (req_valid) begin
                    mem_rd_en = 1'b1;
                    state_d   = split ? ST_SECOND : ST_LAST;
                end
            end
            ST_SECOND: begin
                mem_rd_en     = 1'b1;
                capture_first = 1'b1;
                state_d       = ST_LAST;
            end
            ST_LAST: begin
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            word_hi_q <= '0;
            split_q   <= 1'b0;
            offset_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                word_hi_q <= word_hi;
                split_q   <= split;
                offset_q  <= offset;
            end
        end
    end
endmodule

// File: rtl/ualign_merge.sv
module ualign_merge
    import ualign_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic [DATA_W-1:0] first_word,
    input  logic [DATA_W-1:0] second_word,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] merged
);
    logic [2*DATA_W-1:0] pair;
    assign pair = {first_word, second_word};

    // Result lane i is byte (offset + i) of the two-word big-endian stream.
    for (genvar lane = 0; lane < BYTES; lane++) begin : g_lane
        always_comb begin
            int src;
            src = int'(offset) + lane;
            merged[lane_lsb(lane, BYTES) +: BYTE_W] =
                pair[lane_lsb(src, 2*BYTES) +: BYTE_W];
        end
    end
endmodule

// File: rtl/ualign_read_combiner.sv
module ualign_read_combiner
    import ualign_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BYTES  = 4,
    localparam int OFF_W   = $clog2(BYTES),
    localparam int WADDR_W = ADDR_W - OFF_W,
    localparam int DATA_W  = BYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               mem_rd_en,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata
);
    logic [WADDR_W-1:0] word_lo, word_hi;
    logic [OFF_W-1:0]   offset, offset_q;
    logic               split, split_q;
    logic               capture_first, finish;
    logic [DATA_W-1:0]  first_q, merged, first_sel;
    logic [OFF_W-1:0]   off_sel;

    ualign_addr_split #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_split (
        .byte_addr (req_addr),
        .word_lo   (word_lo),
        .word_hi   (word_hi),
        .offset    (offset),
        .split     (split)
    );

    ualign_seq #(.WADDR_W(WADDR_W), .OFF_W(OFF_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .word_lo       (word_lo),
        .word_hi       (word_hi),
        .offset        (offset),
        .split         (split),
        .req_ready     (req_ready),
        .mem_rd_en     (mem_rd_en),
        .mem_addr      (mem_addr),
        .capture_first (capture_first),
        .finish        (finish),
        .split_q       (split_q),
        .offset_q      (offset_q)
    );

    // Aligned: the single returned word passes straight through.
    assign first_sel = split_q ? first_q  : mem_rdata;
    assign off_sel   = split_q ? offset_q : '0;

    ualign_merge #(.BYTES(BYTES)) u_merge (
        .first_word  (first_sel),
        .second_word (mem_rdata),
        .offset      (off_sel),
        .merged      (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (capture_first) first_q <= mem_rdata;
            rsp_valid <= finish;
            if (finish) rsp_data <= merged;
        end
    end
endmodule

// File: rtl/ualign_read_combiner_chk.sv
module ualign_read_combiner_chk #(
    parameter int ADDR_W = 12,
    parameter int BYTES  = 4,
    localparam int OFF_W   = $clog2(BYTES),
    localparam int WADDR_W = ADDR_W - OFF_W,
    localparam int DATA_W  = BYTES * 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               mem_rd_en,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  mem_rdata
);
    logic               acc, acc_al, acc_un;
    logic [WADDR_W-1:0] next_word;

    assign acc       = req_valid && req_ready;
    assign acc_al    = acc && (req_addr[OFF_W-1:0] == '0);
    assign acc_un    = acc && (req_addr[OFF_W-1:0] != '0);
    assign next_word = req_addr[ADDR_W-1:OFF_W] + {{(WADDR_W-1){1'b0}}, 1'b1};

    a_r1_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |-> !mem_rd_en);

    a_r2_read_on_accept: assert property (@(posedge clk) disable iff (rst)
        acc |-> (mem_rd_en && mem_addr == req_addr[ADDR_W-1:OFF_W]));

    a_r3_aligned_resp: assert property (@(posedge clk) disable iff (rst)
        acc_al |=> (!mem_rd_en ##1 (rsp_valid && rsp_data == $past(mem_rdata))));

    a_r4_second_read: assert property (@(posedge clk) disable iff (rst)
        acc_un |=> (mem_rd_en && mem_addr == $past(next_word)));

    a_r5_split_latency: assert property (@(posedge clk) disable iff (rst)
        acc_un |=> ##1 (!rsp_valid && !req_ready && !mem_rd_en));

    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind ualign_read_combiner ualign_read_combiner_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
);

// File: tb/tb_ualign_read_combiner.sv
`timescale 1ns/1ps
module tb_ualign_read_combiner;
    localparam int AW = 12;
    localparam int WW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rsp_valid, mem_rd_en;
    logic [31:0]   rsp_data, mem_rdata;
    logic [WW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ualign_read_combiner #(.ADDR_W(AW), .BYTES(4)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    // Memory image: byte at address a holds (a + 1) mod 256 (R10 lane order).
    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a % (1 << AW)) + 1);
    endfunction

    function automatic logic [31:0] word_at(input int w);
        return {mem_byte(4*w), mem_byte(4*w+1), mem_byte(4*w+2), mem_byte(4*w+3)};
    endfunction

    function automatic logic [31:0] expect_at(input int a);
        return {mem_byte(a), mem_byte(a+1), mem_byte(a+2), mem_byte(a+3)};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= word_at(int'(mem_addr));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 mem_rd_en", 32'(mem_rd_en), 32'd0);
    endtask

    // One read; optionally hold a stray request during the busy window (R7).
    task automatic t_read(input logic [AW-1:0] a, input bit intrude);
        bit            un;
        logic [WW-1:0] w, wn;
        un = (a[1:0] != 2'b00);
        w  = a[AW-1:2];
        wn = w + 10'd1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; #1;
        check("R2 ready at accept", 32'(req_ready), 32'd1);
        check("R2 read strobe", 32'(mem_rd_en), 32'd1);
        check("R2 first word addr", 32'(mem_addr), 32'(w));
        @(negedge clk);
        if (intrude) begin req_valid = 1'b1; req_addr = a ^ 12'h5A4; end
        else req_valid = 1'b0;
        #1;
        check("R7 ready low", 32'(req_ready), 32'd0);
        check("R9 no early rsp", 32'(rsp_valid), 32'd0);
        if (un) begin
            check("R4 second strobe", 32'(mem_rd_en), 32'd1);
            check("R4 R8 second word addr", 32'(mem_addr), 32'(wn));
        end else begin
            check("R3 single read", 32'(mem_rd_en), 32'd0);
        end
        @(negedge clk);
        if (un) begin
            req_valid = intrude; #1;
            check("R7 still busy", 32'(req_ready), 32'd0);
            check("R7 no stray read", 32'(mem_rd_en), 32'd0);
            check("R5 no rsp yet", 32'(rsp_valid), 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0; #1;
        check(un ? "R5 rsp_valid" : "R3 rsp_valid", 32'(rsp_valid), 32'd1);
        check(un ? "R5 R6 R8 data" : "R3 R10 data", rsp_data, expect_at(int'(a)));
        @(negedge clk); #1;
        check("R9 pulse ends", 32'(rsp_valid), 32'd0);
        check("R1 idle no read", 32'(mem_rd_en), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read(12'h000, 1'b0);              // R3 aligned
        t_read(12'h001, 1'b0);              // R5: 0x02030405
        check("R5 example value", expect_at(1), 32'h02030405);
        t_read(12'h002, 1'b0);              // R6 offset 2
        t_read(12'h003, 1'b0);              // R6 offset 3
        t_read(12'h104, 1'b0);              // R3 mid memory
        t_read(12'hFFC, 1'b0);              // R8 last aligned word
        t_read(12'hFFD, 1'b0);              // R8 wrap, expect FEFF0001
        check("R8 wrap value", expect_at(12'hFFD), 32'hFEFF0001);
        t_read(12'h005, 1'b1);              // R7 stray request, split
        t_read(12'h008, 1'b1);              // R7 stray request, aligned
        t_read(12'hFFF, 1'b1);              // R8 R6 wrap at offset 3
        finish_run();
    end
endmodule